// File: doc/BRIEF.md
# Two-Sharer Direct Migration Trigger

This block sits beside one bank of a last-level cache that holds a single copy of every line. It decides, line by line, when a line should leave this bank for the bank of another tile. For each resident line it records the first remote core that touches the line and counts how many times in a row that core has accessed it. Any access by the core of this tile sets the count back to zero. If a second, different remote core touches the line, the line is marked as widely shared and is never moved. When the count reaches a threshold, the block emits a one-cycle migration pulse that names the line (set and way) and the target tile. At the same time it raises a message to the line's home directory, saying that the target tile is now the line's host.

Access events arrive on a valid/ready stream carrying set, way and requester id. The home-update message leaves on a valid/ready stream. While that message waits for `hupd_ready`, the access stream is held off, so no second migration can overwrite it. The sender must then keep its access and its fields steady until `acc_ready` returns. Fill or evict of a line (`line_clr`) and the acknowledge of a finished move (`mig_ack`) are plain one-cycle strobes. Moving the data and carrying the messages are done elsewhere.

Top module: `mig_trigger`

## Requirements
- R1: After reset `mig_valid` and `hupd_valid` are 0 and `acc_ready` is 1.
- R2: An accepted access whose requester equals `local_id` returns the line's streak count to zero. A later migration then needs THRESH further remote accesses.
- R3: The first remote access to a clean line counts as 1. When the streak from that single remote requester reaches THRESH (default 3), `mig_valid` is 1 in the cycle after the accepting clock edge. In that cycle `mig_set`/`mig_way` give the line and `mig_target` gives that requester's id.
- R4: An access from a second remote id that differs from the recorded sharer marks the line as multiply shared and freezes its count. Such a line never migrates until it is cleared.
- R5: `mig_valid` is high for exactly one cycle per migration.
- R6: `hupd_valid` rises in the same cycle as `mig_valid`. The message carries the same set and way, with `hupd_host` equal to the target. It stays high with stable fields until a cycle with `hupd_ready` high.
- R7: While `hupd_valid` is 1, `acc_ready` is 0 and no access is accepted.
- R8: After a migration, accesses to that line have no effect until `mig_ack` names the same set and way. The acknowledge clears the line's state, so a fresh streak of THRESH then migrates again.
- R9: `line_clr` (fill or evict) clears the named line's sharer id, multiple-sharer flag and count, whether it is in mid-streak or frozen.
- R10: Each line, indexed by set and way, keeps its own state. An access to one line never changes the outcome for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id | input | ID_W | Tile id of this bank's own core |
| acc_valid | input | 1 | Access event valid |
| acc_ready | output | 1 | Access event accepted when high with acc_valid |
| acc_set | input | SET_W | Set of accessed line |
| acc_way | input | WAY_W | Way of accessed line |
| acc_req | input | ID_W | Requesting core id |
| line_clr | input | 1 | Fill or evict strobe for one line |
| clr_set | input | SET_W | Set of the filled or evicted line |
| clr_way | input | WAY_W | Way of the filled or evicted line |
| mig_ack | input | 1 | Move of a migrated line has finished |
| ack_set | input | SET_W | Set of acknowledged line |
| ack_way | input | WAY_W | Way of acknowledged line |
| mig_valid | output | 1 | One-cycle migration request |
| mig_set | output | SET_W | Set of line to migrate |
| mig_way | output | WAY_W | Way of line to migrate |
| mig_target | output | ID_W | Destination tile |
| hupd_valid | output | 1 | Home-directory update valid |
| hupd_ready | input | 1 | Home-directory update taken |
| hupd_set | output | SET_W | Set of moved line |
| hupd_way | output | WAY_W | Way of moved line |
| hupd_host | output | ID_W | New host tile of the line |

## Verification
The assertions take for granted that `local_id` stays constant after reset. They also take for granted that the access sender holds each offered event while `acc_ready` is low. A sender that changes `acc_req` mid-offer could otherwise produce a migration whose origin no longer matches what is on the port. The bench drives `local_id` as a fixed constant and only offers an access after it has seen `acc_ready` high. It asserts `mig_ack` only for lines that its model holds as pending. It uses requester ids up to 3 against a default id width of 4, so every id it uses is legal.

// File: rtl/mig_pkg.sv
package mig_pkg;
  // Outcome of one accepted access on one line.
  typedef enum logic [2:0] {
    ACT_IGNORE  = 3'd0,  // line waits for move acknowledge
    ACT_LOCAL   = 3'd1,  // own core touched the line, streak cleared
    ACT_FROZEN  = 3'd2,  // line already has several remote sharers
    ACT_ADVANCE = 3'd3,  // single remote sharer streak grows
    ACT_SPLIT   = 3'd4,  // second remote sharer seen
    ACT_MIGRATE = 3'd5   // streak reached threshold
  } mig_act_e;
endpackage

// File: rtl/mig_line_update.sv
module mig_line_update
  import mig_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int THRESH = 3
) (
  input  logic [ID_W-1:0]   local_id,
  input  logic [ID_W-1:0]   req_id,
  input  logic              cur_has,
  input  logic [ID_W-1:0]   cur_rid,
  input  logic              cur_multi,
  input  logic [THRESH-1:0] cur_cnt,
  input  logic              cur_pend,
  output logic              nxt_has,
  output logic [ID_W-1:0]   nxt_rid,
  output logic              nxt_multi,
  output logic [THRESH-1:0] nxt_cnt,
  output mig_act_e          act
);
  // The streak is a thermometer code: one more set bit per remote access.
  logic [THRESH-1:0] base_cnt;
  logic [THRESH-1:0] inc_cnt;

  assign base_cnt = cur_has ? cur_cnt : '0;

  generate
    if (THRESH == 1) begin : g_one
      assign inc_cnt = 1'b1;
    end else begin : g_shift
      assign inc_cnt = {base_cnt[THRESH-2:0], 1'b1};
    end
  endgenerate

  always_comb begin
    nxt_has   = cur_has;
    nxt_rid   = cur_rid;
    nxt_multi = cur_multi;
    nxt_cnt   = cur_cnt;
    act       = ACT_IGNORE;
    if (cur_pend) begin
      act = ACT_IGNORE;
    end else if (req_id == local_id) begin
      nxt_cnt = '0;
      act     = ACT_LOCAL;
    end else if (cur_multi) begin
      act = ACT_FROZEN;
    end else if (!cur_has || (req_id == cur_rid)) begin
      nxt_has = 1'b1;
      nxt_rid = req_id;
      nxt_cnt = inc_cnt;
      act     = inc_cnt[THRESH-1] ? ACT_MIGRATE : ACT_ADVANCE;
    end else begin
      nxt_multi = 1'b1;
      act       = ACT_SPLIT;
    end
  end
endmodule

// File: rtl/mig_state_array.sv
module mig_state_array #(
  parameter int LINES  = 8,
  parameter int ID_W   = 4,
  parameter int THRESH = 3,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_has,
  output logic [ID_W-1:0]   rd_rid,
  output logic              rd_multi,
  output logic [THRESH-1:0] rd_cnt,
  output logic              rd_pend,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_has,
  input  logic [ID_W-1:0]   wr_rid,
  input  logic              wr_multi,
  input  logic [THRESH-1:0] wr_cnt,
  input  logic              wr_pend,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              ack_en,
  input  logic [IDX_W-1:0]  ack_idx
);
  logic              has_q   [LINES];
  logic [ID_W-1:0]   rid_q   [LINES];
  logic              multi_q [LINES];
  logic [THRESH-1:0] cnt_q   [LINES];
  logic              pend_q  [LINES];

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic wipe;
      assign wipe = (clr_en && (clr_idx == IDX_W'(i))) ||
                    (ack_en && (ack_idx == IDX_W'(i)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          has_q[i]   <= 1'b0;
          rid_q[i]   <= '0;
          multi_q[i] <= 1'b0;
          cnt_q[i]   <= '0;
          pend_q[i]  <= 1'b0;
        end else if (wipe) begin
          has_q[i]   <= 1'b0;
          rid_q[i]   <= '0;
          multi_q[i] <= 1'b0;
          cnt_q[i]   <= '0;
          pend_q[i]  <= 1'b0;
        end else if (wr_en && (wr_idx == IDX_W'(i))) begin
          has_q[i]   <= wr_has;
          rid_q[i]   <= wr_rid;
          multi_q[i] <= wr_multi;
          cnt_q[i]   <= wr_cnt;
          pend_q[i]  <= wr_pend;
        end
      end
    end
  endgenerate

  assign rd_has   = has_q[rd_idx];
  assign rd_rid   = rid_q[rd_idx];
  assign rd_multi = multi_q[rd_idx];
  assign rd_cnt   = cnt_q[rd_idx];
  assign rd_pend  = pend_q[rd_idx];
endmodule

// File: rtl/mig_home_msg.sv
module mig_home_msg #(
  parameter int SET_W = 2,
  parameter int WAY_W = 1,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] ld_set,
  input  logic [WAY_W-1:0] ld_way,
  input  logic [ID_W-1:0]  ld_host,
  input  logic             ready,
  output logic             valid,
  output logic             pulse,
  output logic [SET_W-1:0] msg_set,
  output logic [WAY_W-1:0] msg_way,
  output logic [ID_W-1:0]  msg_host
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      pulse    <= 1'b0;
      msg_set  <= '0;
      msg_way  <= '0;
      msg_host <= '0;
    end else begin
      pulse <= load;
      if (load) begin
        valid    <= 1'b1;
        msg_set  <= ld_set;
        msg_way  <= ld_way;
        msg_host <= ld_host;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mig_trigger.sv
module mig_trigger
  import mig_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ID_W   = 4,
  parameter int THRESH = 3,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  local_id,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [ID_W-1:0]  acc_req,
  input  logic             line_clr,
  input  logic [SET_W-1:0] clr_set,
  input  logic [WAY_W-1:0] clr_way,
  input  logic             mig_ack,
  input  logic [SET_W-1:0] ack_set,
  input  logic [WAY_W-1:0] ack_way,
  output logic             mig_valid,
  output logic [SET_W-1:0] mig_set,
  output logic [WAY_W-1:0] mig_way,
  output logic [ID_W-1:0]  mig_target,
  output logic             hupd_valid,
  input  logic             hupd_ready,
  output logic [SET_W-1:0] hupd_set,
  output logic [WAY_W-1:0] hupd_way,
  output logic [ID_W-1:0]  hupd_host
);
  localparam int LINES = SETS * WAYS;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  function automatic logic [IDX_W-1:0] line_of(input logic [SET_W-1:0] s,
                                               input logic [WAY_W-1:0] w);
    return IDX_W'(int'(s) * WAYS + int'(w));
  endfunction

  logic              acc_fire;
  logic [IDX_W-1:0]  acc_idx;
  logic              cur_has, cur_multi, cur_pend;
  logic [ID_W-1:0]   cur_rid;
  logic [THRESH-1:0] cur_cnt;
  logic              nxt_has, nxt_multi;
  logic [ID_W-1:0]   nxt_rid;
  logic [THRESH-1:0] nxt_cnt;
  mig_act_e          act;
  logic              write_line;
  logic              fire_mig;
  logic              msg_busy;

  assign acc_ready  = !msg_busy;
  assign acc_fire   = acc_valid && acc_ready;
  assign acc_idx    = line_of(acc_set, acc_way);
  assign fire_mig   = acc_fire && (act == ACT_MIGRATE);
  assign write_line = acc_fire && (act != ACT_IGNORE) && (act != ACT_FROZEN);

  mig_state_array #(
    .LINES (LINES),
    .ID_W  (ID_W),
    .THRESH(THRESH)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (acc_idx),
    .rd_has  (cur_has),
    .rd_rid  (cur_rid),
    .rd_multi(cur_multi),
    .rd_cnt  (cur_cnt),
    .rd_pend (cur_pend),
    .wr_en   (write_line),
    .wr_idx  (acc_idx),
    .wr_has  (nxt_has),
    .wr_rid  (nxt_rid),
    .wr_multi(nxt_multi),
    .wr_cnt  (nxt_cnt),
    .wr_pend (act == ACT_MIGRATE),
    .clr_en  (line_clr),
    .clr_idx (line_of(clr_set, clr_way)),
    .ack_en  (mig_ack),
    .ack_idx (line_of(ack_set, ack_way))
  );

  mig_line_update #(
    .ID_W  (ID_W),
    .THRESH(THRESH)
  ) u_update (
    .local_id (local_id),
    .req_id   (acc_req),
    .cur_has  (cur_has),
    .cur_rid  (cur_rid),
    .cur_multi(cur_multi),
    .cur_cnt  (cur_cnt),
    .cur_pend (cur_pend),
    .nxt_has  (nxt_has),
    .nxt_rid  (nxt_rid),
    .nxt_multi(nxt_multi),
    .nxt_cnt  (nxt_cnt),
    .act      (act)
  );

  mig_home_msg #(
    .SET_W(SET_W),
    .WAY_W(WAY_W),
    .ID_W (ID_W)
  ) u_msg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fire_mig),
    .ld_set  (acc_set),
    .ld_way  (acc_way),
    .ld_host (acc_req),
    .ready   (hupd_ready),
    .valid   (msg_busy),
    .pulse   (mig_valid),
    .msg_set (hupd_set),
    .msg_way (hupd_way),
    .msg_host(hupd_host)
  );

  assign hupd_valid = msg_busy;
  assign mig_set    = hupd_set;
  assign mig_way    = hupd_way;
  assign mig_target = hupd_host;
endmodule

// File: rtl/mig_trigger_chk.sv
module mig_trigger_chk #(
  parameter int SET_W = 2,
  parameter int WAY_W = 1,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ID_W-1:0]  local_id,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             mig_valid,
  input logic [ID_W-1:0]  mig_target,
  input logic             hupd_valid,
  input logic             hupd_ready,
  input logic [SET_W-1:0] hupd_set,
  input logic [WAY_W-1:0] hupd_way,
  input logic [ID_W-1:0]  hupd_host
);
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |=> !mig_valid);

  // R3
  remote_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> (mig_target != local_id));

  // R3
  accepted_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> $past(acc_valid && acc_ready));

  // R6
  msg_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hupd_valid) |-> mig_valid);

  // R6
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hupd_valid && !hupd_ready) |=>
      (hupd_valid && $stable(hupd_set) && $stable(hupd_way) && $stable(hupd_host)));

  // R7
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hupd_valid |-> !acc_ready);
endmodule

bind mig_trigger mig_trigger_chk #(
  .SET_W(SET_W),
  .WAY_W(WAY_W),
  .ID_W (ID_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .local_id  (local_id),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .mig_valid (mig_valid),
  .mig_target(mig_target),
  .hupd_valid(hupd_valid),
  .hupd_ready(hupd_ready),
  .hupd_set  (hupd_set),
  .hupd_way  (hupd_way),
  .hupd_host (hupd_host)
);

// File: tb/test_mig_trigger.sv
module test_mig_trigger;
  localparam int SETS = 4, WAYS = 2, ID_W = 4, TH = 3;
  localparam int SET_W = 2, WAY_W = 1, LINES = SETS * WAYS;
  localparam logic [ID_W-1:0] LOC = 4'd0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, line_clr = 0, mig_ack = 0, hupd_ready = 0;
  logic [SET_W-1:0] acc_set = '0, clr_set = '0, ack_set = '0;
  logic [WAY_W-1:0] acc_way = '0, clr_way = '0, ack_way = '0;
  logic [ID_W-1:0]  acc_req = '0;
  logic acc_ready, mig_valid, hupd_valid;
  logic [SET_W-1:0] mig_set, hupd_set;
  logic [WAY_W-1:0] mig_way, hupd_way;
  logic [ID_W-1:0]  mig_target, hupd_host;

  int errors = 0, checks = 0;
  bit m_has[LINES], m_multi[LINES], m_pend[LINES];
  int m_rid[LINES], m_cnt[LINES];

  always #2.5 clk = ~clk;

  mig_trigger i_mig_trigger (
    .clk(clk), .rst_n(rst_n), .local_id(LOC),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_set(acc_set),
    .acc_way(acc_way), .acc_req(acc_req),
    .line_clr(line_clr), .clr_set(clr_set), .clr_way(clr_way),
    .mig_ack(mig_ack), .ack_set(ack_set), .ack_way(ack_way),
    .mig_valid(mig_valid), .mig_set(mig_set), .mig_way(mig_way),
    .mig_target(mig_target), .hupd_valid(hupd_valid), .hupd_ready(hupd_ready),
    .hupd_set(hupd_set), .hupd_way(hupd_way), .hupd_host(hupd_host)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wipe_model(input int i);
    m_has[i] = 0; m_multi[i] = 0; m_pend[i] = 0; m_rid[i] = 0; m_cnt[i] = 0;
  endtask

  // R9: fill or evict strobe
  task automatic clear_line(input int s, input int w);
    clr_set = SET_W'(s); clr_way = WAY_W'(w); line_clr = 1;
    @(negedge clk); line_clr = 0;
    wipe_model(s * WAYS + w);
  endtask

  // R8: move acknowledge
  task automatic ack_line(input int s, input int w);
    ack_set = SET_W'(s); ack_way = WAY_W'(w); mig_ack = 1;
    @(negedge clk); mig_ack = 0;
    wipe_model(s * WAYS + w);
  endtask

  task automatic access(input int s, input int w, input int r, input string tag);
    int  i = s * WAYS + w;
    bit  fire = 0;
    if (m_pend[i]) begin
    end else if (r == int'(LOC)) m_cnt[i] = 0;
    else if (m_multi[i]) begin
    end else if (!m_has[i] || m_rid[i] == r) begin
      m_cnt[i] = m_has[i] ? m_cnt[i] + 1 : 1;
      m_has[i] = 1; m_rid[i] = r;
      if (m_cnt[i] == TH) begin fire = 1; m_pend[i] = 1; end
    end else m_multi[i] = 1;
    while (!acc_ready) @(negedge clk);
    acc_set = SET_W'(s); acc_way = WAY_W'(w); acc_req = ID_W'(r); acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    chk(mig_valid == fire, {tag, " mig_valid"}, int'(mig_valid), int'(fire));
    if (fire && mig_valid) begin
      chk(mig_set == SET_W'(s) && mig_way == WAY_W'(w), {tag, " R3 line"},
          int'(mig_set) * WAYS + int'(mig_way), i);
      chk(mig_target == ID_W'(r), {tag, " R3 target"}, int'(mig_target), r);
      chk(hupd_valid && hupd_host == ID_W'(r) && hupd_set == SET_W'(s) &&
          hupd_way == WAY_W'(w), {tag, " R6 message"}, int'(hupd_host), r);
      @(negedge clk);
      chk(!mig_valid, {tag, " R5 pulse width"}, int'(mig_valid), 0);
      chk(!acc_ready && hupd_valid, {tag, " R7 held off"}, int'(acc_ready), 0);
      @(negedge clk);
      chk(hupd_valid && hupd_host == ID_W'(r), {tag, " R6 hold"}, int'(hupd_valid), 1);
      hupd_ready = 1;
      @(negedge clk);
      hupd_ready = 0;
      chk(!hupd_valid && acc_ready, {tag, " R6 release"}, int'(hupd_valid), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) wipe_model(i);
    repeat (3) @(negedge clk);
    // R1
    chk(!mig_valid && !hupd_valid && acc_ready, "R1 reset outputs",
        int'(mig_valid) + int'(hupd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mig_valid && !hupd_valid && acc_ready, "R1 after release",
        int'(mig_valid) + int'(hupd_valid), 0);

    // R3 and R10: every line with every remote id
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        for (int r = 1; r < 4; r++) begin
          for (int k = 0; k < TH; k++) access(s, w, r, "R3 R10 sweep");
          ack_line(s, w);
        end

    // R2: local access restarts the streak
    access(0, 0, 1, "R2"); access(0, 0, 1, "R2"); access(0, 0, 0, "R2");
    access(0, 0, 1, "R2"); access(0, 0, 1, "R2"); access(0, 0, 1, "R2 fire");
    ack_line(0, 0);

    // R4: second remote sharer freezes the line
    access(1, 1, 1, "R4"); access(1, 1, 2, "R4 split");
    for (int k = 0; k < 5; k++) begin access(1, 1, 1, "R4"); access(1, 1, 2, "R4"); end
    access(1, 1, 0, "R4");
    for (int k = 0; k < 4; k++) access(1, 1, 1, "R4 frozen");
    clear_line(1, 1);
    for (int k = 0; k < TH; k++) access(1, 1, 2, "R9 after split");
    ack_line(1, 1);

    // R8: pending line ignores accesses until acknowledged
    for (int k = 0; k < TH; k++) access(2, 1, 3, "R8 fire");
    for (int k = 0; k < 4; k++) access(2, 1, 3, "R8 ignored");
    access(2, 1, 0, "R8 ignored"); access(2, 1, 2, "R8 ignored");
    ack_line(2, 1);
    for (int k = 0; k < TH; k++) access(2, 1, 2, "R8 after ack");
    ack_line(2, 1);

    // R9: clear in mid-streak
    access(3, 0, 1, "R9"); access(3, 0, 1, "R9");
    clear_line(3, 0);
    access(3, 0, 1, "R9"); access(3, 0, 1, "R9"); access(3, 0, 1, "R9 fire");
    ack_line(3, 0);

    // R10: every 4-access pattern over ids 0..2 on every line, interleaved
    for (int p = 0; p < 81; p++)
      for (int i = 0; i < LINES; i++) begin
        clear_line(i / WAYS, i % WAYS);
        for (int k = 0; k < 4; k++) begin
          int d = p;
          for (int q = 0; q < k; q++) d = d / 3;
          access(i / WAYS, i % WAYS, d % 3, "R10 pattern");
          access((i + 1) % LINES / WAYS, (i + 1) % LINES % WAYS, 3, "R10 neighbour");
        end
        if (m_pend[i]) ack_line(i / WAYS, i % WAYS);
      end

    summary();
    $finish;
  end
endmodule